// File: doc/BRIEF.md
# Dispatch Group Slot Allocator

This block rules, once per clock, on a single candidate instruction offered to a dispatch stage that packs operations into groups of five slots. It looks at the execution-unit class of the candidate, its placement flags and the state of the group now being built. It then either accepts the candidate into the group or refuses it. A refusal closes the group, and the candidate is offered again in a fresh group. The block tracks how many slots are in use and whether the count register has been written in this group. When the group closes, it clears that state and pulses a group-start indication.

A refused candidate stays on the inputs, with valid high and every field unchanged, until it is accepted. A refusal that happens while slots other than the branch slot are still free also raises a request to pad the group with a no-op. Opcode decoding and address comparison are done upstream. The candidate arrives already classified.

Top module: `dgsa_top`

## Requirements
- R1: The unit class code is 0 pseudo, 1 fixed-point, 2 load/store, 3 floating-point, 4 vector ALU, 5 vector permute, 6 condition-register, 7 branch. A valid pseudo candidate (code 0) is always accepted. It leaves the slot count unchanged, and its count-register-write flag is ignored.
- R2: A candidate flagged first-only or single is refused unless the slot count is zero.
- R3: An accepted cracked candidate adds two to the slot count. A cracked candidate is refused when more than two slots are filled.
- R4: Candidates of classes 1 to 5 are refused when the slot count is four, because the last slot is reserved for a branch.
- R5: A condition-register candidate (code 6) is accepted only while fewer than two slots are filled.
- R6: Accepting a single-flagged candidate sets the slot count to four. Accepting a branch (code 7) closes the group.
- R7: After a non-pseudo candidate with the count-register-write flag is accepted, a candidate with the branch-through-count-register flag is refused in the same group. The restriction ends when the group closes.
- R8: A refusal closes the group. In the next cycle the slot count reads zero and group_start is high for exactly that cycle. A group closed by a branch behaves the same way.
- R9: noop_req is high exactly when a refusal happens while the slot count is below four.
- R10: The slot count never exceeds four. Accept and hazard are never high together, and both are low while cand_valid is low.
- R11: During and after reset, the slot count is zero and accept, hazard, noop_req and group_start are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cand_valid | input | 1 | Candidate present |
| cand_unit | input | 3 | Execution-unit class code (see R1) |
| cand_first | input | 1 | Candidate must start a group |
| cand_single | input | 1 | Candidate occupies the whole group |
| cand_cracked | input | 1 | Candidate takes two slots |
| cand_ctr_write | input | 1 | Candidate writes the count register |
| cand_ctr_branch | input | 1 | Candidate branches through the count register |
| issue_accept | output | 1 | Candidate joins the current group |
| group_hazard | output | 1 | Candidate refused; group ends, retry |
| noop_req | output | 1 | Pad the closing group with a no-op |
| slot_count | output | 3 | Slots filled in the current group |
| group_start | output | 1 | First cycle of a new group |

## Verification
A wrong slot count shows at the ports in the very next cycle after the accept that corrupted it. It appears as a wrong slot_count value, and then as a wrong verdict on the next candidate whose class limit depends on that count. A count-register flag that is stuck, or that is never cleared, shows up only when a branch through the count register is offered. The bench therefore pairs a write and such a branch both within one group and across a group boundary. A missed or extra group close is seen one cycle later on group_start and as a slot count that failed to reset.

// File: rtl/dgsa_pkg.sv
package dgsa_pkg;

  typedef enum logic [2:0] {
    UNIT_PSEUDO = 3'd0,
    UNIT_FIX    = 3'd1,
    UNIT_LDST   = 3'd2,
    UNIT_FLT    = 3'd3,
    UNIT_VALU   = 3'd4,
    UNIT_VPERM  = 3'd5,
    UNIT_CRU    = 3'd6,
    UNIT_BRU    = 3'd7
  } unit_e;

endpackage

// File: rtl/dgsa_unit_decode.sv
module dgsa_unit_decode
  import dgsa_pkg::*;
(
  input  unit_e unit_i,
  output logic  is_pseudo_o,
  output logic  is_ordinary_o,
  output logic  is_cr_o,
  output logic  is_branch_o
);

  always_comb begin
    is_pseudo_o   = 1'b0;
    is_ordinary_o = 1'b0;
    is_cr_o       = 1'b0;
    is_branch_o   = 1'b0;
    unique case (unit_i)
      UNIT_PSEUDO: is_pseudo_o   = 1'b1;
      UNIT_FIX,
      UNIT_LDST,
      UNIT_FLT,
      UNIT_VALU,
      UNIT_VPERM:  is_ordinary_o = 1'b1;
      UNIT_CRU:    is_cr_o       = 1'b1;
      UNIT_BRU:    is_branch_o   = 1'b1;
      default:     is_pseudo_o   = 1'b1;
    endcase
  end

endmodule

// File: rtl/dgsa_slot_rules.sv
module dgsa_slot_rules #(
  parameter int CNT_W       = 3,
  parameter int LAST_FREE   = 4,
  parameter int CRACK_MAX   = 2,
  parameter int CR_WINDOW   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic             is_pseudo_i,
  input  logic             is_ordinary_i,
  input  logic             is_cr_i,
  input  logic             first_i,
  input  logic             single_i,
  input  logic             cracked_i,
  input  logic             ctr_branch_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ctr_seen_i,
  output logic             accept_o,
  output logic             hazard_o,
  output logic             noop_o
);

  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(LAST_FREE);
  localparam logic [CNT_W-1:0] CNT_CRACK = CNT_W'(CRACK_MAX);
  localparam logic [CNT_W-1:0] CNT_CRWIN = CNT_W'(CR_WINDOW);

  logic viol_place;
  logic viol_crack;
  logic viol_tail;
  logic viol_cr;
  logic viol_ctr;
  logic refuse;

  always_comb begin
    viol_place = (first_i || single_i) && (cnt_i != '0);
    viol_crack = cracked_i && (cnt_i > CNT_CRACK);
    viol_tail  = is_ordinary_i && (cnt_i == CNT_LAST);
    viol_cr    = is_cr_i && (cnt_i >= CNT_CRWIN);
    viol_ctr   = ctr_branch_i && ctr_seen_i;
    refuse     = !is_pseudo_i &&
                 (viol_place || viol_crack || viol_tail || viol_cr || viol_ctr);
    accept_o   = valid_i && !refuse;
    hazard_o   = valid_i && refuse;
    noop_o     = hazard_o && (cnt_i != CNT_LAST);
  end

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept_o && hazard_o)); // R10

  AST_NOOP_WITH_HAZ: assert property (@(posedge clk) disable iff (!rst_n)
    noop_o |-> hazard_o); // R9

  AST_PLACE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && !is_pseudo_i && (first_i || single_i)) |-> (cnt_i == '0)); // R2

  AST_CR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && is_cr_i) |-> (cnt_i < CNT_CRWIN)); // R5

endmodule

// File: rtl/dgsa_group_tracker.sv
module dgsa_group_tracker #(
  parameter int CNT_W     = 3,
  parameter int LAST_FREE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic             accept_i,
  input  logic             hazard_i,
  input  logic             is_pseudo_i,
  input  logic             is_branch_i,
  input  logic             single_i,
  input  logic             cracked_i,
  input  logic             ctr_write_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ctr_seen_o,
  output logic             start_o
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LAST_FREE);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_TWO  = CNT_W'(2);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ctr_q, ctr_d;
  logic             start_q, start_d;
  logic             close;
  logic             upd_en;

  always_comb begin
    close   = valid_i && (hazard_i || (accept_i && is_branch_i));
    cnt_d   = cnt_q;
    ctr_d   = ctr_q;
    start_d = 1'b0;
    if (close) begin
      cnt_d   = '0;
      ctr_d   = 1'b0;
      start_d = 1'b1;
    end else if (valid_i && accept_i && !is_pseudo_i) begin
      if (single_i)
        cnt_d = CNT_LAST;
      else if (cracked_i)
        cnt_d = cnt_q + CNT_TWO;
      else
        cnt_d = cnt_q + CNT_ONE;
      ctr_d = ctr_q || ctr_write_i;
    end
    upd_en = valid_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ctr_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      ctr_q <= ctr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      start_q <= 1'b0;
    else
      start_q <= start_d;
  end

  assign cnt_o      = cnt_q;
  assign ctr_seen_o = ctr_q;
  assign start_o    = start_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST); // R10

  AST_CLOSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && hazard_i) |=> (cnt_q == '0 && !ctr_q && start_q)); // R8

  AST_SINGLE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && accept_i && single_i && !is_pseudo_i && !is_branch_i)
      |=> (cnt_q == CNT_LAST)); // R6

  AST_BRANCH_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && accept_i && is_branch_i) |=> (cnt_q == '0 && start_q)); // R6

  AST_PSEUDO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && accept_i && is_pseudo_i) |=> $stable(cnt_q)); // R1

endmodule

// File: rtl/dgsa_top.sv
module dgsa_top
  import dgsa_pkg::*;
#(
  parameter int GROUP_SLOTS = 5,
  parameter int CR_WINDOW   = 2,
  parameter int CNT_W       = $clog2(GROUP_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cand_valid,
  input  logic [2:0]       cand_unit,
  input  logic             cand_first,
  input  logic             cand_single,
  input  logic             cand_cracked,
  input  logic             cand_ctr_write,
  input  logic             cand_ctr_branch,
  output logic             issue_accept,
  output logic             group_hazard,
  output logic             noop_req,
  output logic [CNT_W-1:0] slot_count,
  output logic             group_start
);

  localparam int LAST_FREE = GROUP_SLOTS - 1;
  localparam int CRACK_MAX = GROUP_SLOTS - 3;

  logic             is_pseudo, is_ordinary, is_cr, is_branch;
  logic [CNT_W-1:0] cnt;
  logic             ctr_seen;
  logic             acc, haz, noop;

  dgsa_unit_decode u_decode (
    .unit_i        (unit_e'(cand_unit)),
    .is_pseudo_o   (is_pseudo),
    .is_ordinary_o (is_ordinary),
    .is_cr_o       (is_cr),
    .is_branch_o   (is_branch)
  );

  dgsa_slot_rules #(
    .CNT_W     (CNT_W),
    .LAST_FREE (LAST_FREE),
    .CRACK_MAX (CRACK_MAX),
    .CR_WINDOW (CR_WINDOW)
  ) u_rules (
    .clk           (clk),
    .rst_n         (rst_n),
    .valid_i       (cand_valid),
    .is_pseudo_i   (is_pseudo),
    .is_ordinary_i (is_ordinary),
    .is_cr_i       (is_cr),
    .first_i       (cand_first),
    .single_i      (cand_single),
    .cracked_i     (cand_cracked),
    .ctr_branch_i  (cand_ctr_branch),
    .cnt_i         (cnt),
    .ctr_seen_i    (ctr_seen),
    .accept_o      (acc),
    .hazard_o      (haz),
    .noop_o        (noop)
  );

  dgsa_group_tracker #(
    .CNT_W     (CNT_W),
    .LAST_FREE (LAST_FREE)
  ) u_tracker (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (cand_valid),
    .accept_i    (acc),
    .hazard_i    (haz),
    .is_pseudo_i (is_pseudo),
    .is_branch_i (is_branch),
    .single_i    (cand_single),
    .cracked_i   (cand_cracked),
    .ctr_write_i (cand_ctr_write),
    .cnt_o       (cnt),
    .ctr_seen_o  (ctr_seen),
    .start_o     (group_start)
  );

  assign issue_accept = acc;
  assign group_hazard = haz;
  assign noop_req     = noop;
  assign slot_count   = cnt;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cand_valid |-> (!issue_accept && !group_hazard)); // R10

  AST_PSEUDO_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && cand_unit == 3'd0) |-> issue_accept); // R1

endmodule

// File: tb/tb_dgsa_top.sv
module tb_dgsa_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cand_valid = 1'b0;
  logic [2:0] cand_unit = 3'd0;
  logic       cand_first = 1'b0, cand_single = 1'b0, cand_cracked = 1'b0;
  logic       cand_ctr_write = 1'b0, cand_ctr_branch = 1'b0;
  logic       issue_accept, group_hazard, noop_req, group_start;
  logic [2:0] slot_count;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dgsa_top dut (
    .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_unit(cand_unit),
    .cand_first(cand_first), .cand_single(cand_single), .cand_cracked(cand_cracked),
    .cand_ctr_write(cand_ctr_write), .cand_ctr_branch(cand_ctr_branch),
    .issue_accept(issue_accept), .group_hazard(group_hazard), .noop_req(noop_req),
    .slot_count(slot_count), .group_start(group_start)
  );

  // scoreboard queues: packed {acc, haz, noop, start, cnt[2:0]} plus a tag
  logic [6:0] exp_q[$];
  string      tag_q[$];

  // reference state built from the requirements
  int m_cnt = 0;
  bit m_ctr = 1'b0;
  bit m_start = 1'b0;

  task automatic check(input int act, input int exp, input string tag, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      logic [6:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(int'(issue_accept), int'(e[6]), t, "accept");
      check(int'(group_hazard), int'(e[5]), t, "hazard");
      check(int'(noop_req),     int'(e[4]), t, "noop");
      check(int'(group_start),  int'(e[3]), t, "group_start");
      check(int'(slot_count),   int'(e[2:0]), t, "slot_count");
    end
  end

  task automatic idle(input string tag);
    @(posedge clk); #1;
    cand_valid = 1'b0;
    exp_q.push_back({1'b0, 1'b0, 1'b0, m_start, 3'(m_cnt)});
    tag_q.push_back(tag);
    m_start = 1'b0;
  endtask

  task automatic send(input int unit, input bit f, input bit s, input bit cr,
                      input bit cw, input bit cb, input string tag);
    bit done = 1'b0;
    while (!done) begin
      bit haz, acc, noop, close;
      @(posedge clk); #1;
      cand_valid = 1'b1; cand_unit = 3'(unit);
      cand_first = f; cand_single = s; cand_cracked = cr;
      cand_ctr_write = cw; cand_ctr_branch = cb;
      haz = 1'b0;
      if (unit != 0) begin
        if ((f || s) && m_cnt != 0) haz = 1'b1;           // R2
        if (cr && m_cnt > 2) haz = 1'b1;                  // R3
        if (unit >= 1 && unit <= 5 && m_cnt == 4) haz = 1'b1; // R4
        if (unit == 6 && m_cnt >= 2) haz = 1'b1;          // R5
        if (cb && m_ctr) haz = 1'b1;                      // R7
      end
      acc  = !haz;
      noop = haz && (m_cnt != 4);                          // R9
      exp_q.push_back({acc, haz, noop, m_start, 3'(m_cnt)});
      tag_q.push_back(tag);
      close = haz || (acc && unit == 7);
      if (close) begin
        m_cnt = 0; m_ctr = 1'b0; m_start = 1'b1;           // R8
      end else begin
        m_start = 1'b0;
        if (unit != 0) begin
          if (s) m_cnt = 4; else if (cr) m_cnt = m_cnt + 2; else m_cnt = m_cnt + 1;
          if (cw) m_ctr = 1'b1;
        end
      end
      done = acc;
    end
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL R10 watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(int'(slot_count), 0, "R11", "slot_count in reset");
    check(int'(issue_accept | group_hazard | noop_req | group_start), 0, "R11", "outputs in reset");
    rst_n = 1'b1;
    idle("R11");
    idle("R10");

    // R4: four ordinary, fifth refused without noop, then retried
    send(1, 0, 0, 0, 0, 0, "R4");
    send(2, 0, 0, 0, 0, 0, "R4");
    send(3, 0, 0, 0, 0, 0, "R4");
    send(4, 0, 0, 0, 0, 0, "R4");
    send(5, 0, 0, 0, 0, 0, "R4");
    // R6 branch closes group
    send(7, 0, 0, 0, 0, 0, "R6");
    // R5 CR window
    send(6, 0, 0, 0, 0, 0, "R5");
    send(1, 0, 0, 0, 0, 0, "R5");
    send(6, 0, 0, 0, 0, 0, "R5");
    // R3 cracked
    send(1, 0, 0, 1, 0, 0, "R3");
    send(2, 0, 0, 0, 0, 0, "R3");
    send(3, 0, 0, 1, 0, 0, "R3");
    // R1 pseudo keeps count, ignores count-register flag
    send(0, 0, 0, 0, 1, 0, "R1");
    send(0, 1, 1, 1, 1, 1, "R1");
    send(7, 0, 0, 0, 0, 1, "R1");
    // R2 first-only and single placement
    send(1, 0, 0, 0, 0, 0, "R2");
    send(1, 1, 0, 0, 0, 0, "R2");
    send(2, 0, 1, 0, 0, 0, "R2");
    send(1, 0, 0, 0, 0, 0, "R6");
    send(7, 0, 0, 0, 0, 0, "R6");
    // R7 count-register write then branch through it
    send(1, 0, 0, 0, 1, 0, "R7");
    send(7, 0, 0, 0, 0, 1, "R7");
    // R8 closing with cracked at limit
    send(1, 0, 0, 1, 0, 0, "R8");
    send(1, 0, 0, 1, 0, 0, "R8");
    send(1, 0, 0, 1, 0, 0, "R8");
    idle("R10");
    // R9 refusal at count four asks no no-op; below four it does
    send(3, 0, 1, 0, 0, 0, "R9");
    send(6, 0, 0, 0, 0, 0, "R9");
    send(6, 0, 0, 0, 0, 0, "R9");
    send(7, 0, 0, 0, 1, 0, "R9");
    idle("R10");
    idle("R10");
    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule